// File: doc/BRIEF.md
# Queued SPI Master with Per-Word Frame Control

This block is an SPI master whose transmit side is fed one word at a time. Each pushed word carries the data to send and its own frame control: which chip-select line to drive, which of the timing attribute sets to use, and whether the chip select should stay asserted after the frame. Pushed words wait in a small transmit queue. A frame engine takes them in order and shifts each one out on the serial pins. The word clocked in during every frame goes into a receive queue. A frame sent with all-zero data therefore works as a plain read.

A control word sets the master enable and the halt flag, and gives each chip-select line its own idle level. It also holds two flush bits, one per queue, that clear themselves. Each attribute set gives the frame length, the clock polarity and phase, the bit order and a half-period divisor. The status outputs report both fill counts, a sticky transmit-overflow flag and a running flag. Software can poll the receive count and pop once it is non-zero.

Top module: `spi_cmdq_master`

## Requirements
- R1: The transmit queue holds 4 words. A push is accepted only while `txCount` is below 4, and `txCount` shows the number of stored words.
- R2: A push while `txCount` is 4 is dropped and sets `txOverflow`. The flag stays set until the transmit queue is flushed.
- R3: The push word has these fields: data in bits 15:0, a one-hot chip-select vector starting at bit 16 (one bit per line), the attribute index at bit 24, and the continuous flag at bit 31.
- R4: A frame is `size+1` bits long, where size is attribute bits 3:0. It produces 2·N edges on `sck`. `running` stays high for (D+1)·(2N+2) clock cycles, where D is attribute bits 15:8.
- R5: Attribute bit 4 is the clock polarity. `sck` rests at this level after a frame that used it. Attribute bit 5 is the clock phase: when clear, `mosi` is sampled on leading edges; when set, it is sampled on trailing edges.
- R6: Attribute bit 6 selects least-significant-bit-first order. When it is clear, the most significant bit of the N-bit word goes out first.
- R7: Every frame adds one N-bit received word to the receive queue, which holds 4 words. A word that arrives while the queue is full is lost. `popData` shows the oldest word, and `popEn` removes it.
- R8: If the continuous flag is set, the frame's chip select stays active after the frame ends. A frame with the flag clear returns the line to its idle level.
- R9: Control bits 8 and up give one idle level per chip-select line. A 1 makes the line idle high and drives it low when it is active.
- R10: No new frame starts while control bit 0 (enable) is clear or control bit 1 (halt) is set. Queued words are kept.
- R11: Control bit 2 empties the transmit queue and control bit 3 empties the receive queue. The queue is emptied in the cycle after the write, and the bit then clears itself.
- R12: After reset both counts are zero, `running` is low, `sck` is low, every chip-select line is idle high, and attribute sets default to 8-bit frames with a divisor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | CFGAW | 0 selects control, k+1 selects attribute set k |
| cfgWdata | input | 32 | Configuration write data |
| pushEn | input | 1 | Push `pushWord` into the transmit queue |
| pushWord | input | 32 | Data plus per-frame control |
| popEn | input | 1 | Remove the oldest received word |
| popData | output | 16 | Oldest received word |
| txCount | output | CNTW | Transmit queue fill count |
| rxCount | output | CNTW | Receive queue fill count |
| txOverflow | output | 1 | Sticky dropped-push flag |
| running | output | 1 | A frame is in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | NCS | Chip-select lines |

## Verification
The hardest states to reach from the ports are a full transmit queue and a full receive queue. Frames drain the transmit queue within a cycle of each push. The bench therefore sets halt before it stacks words, and it checks the overflow and the flush while nothing is moving. It then releases halt so that four frames fill the receive queue before a fifth frame arrives with nowhere to go. The held chip select is checked in the idle gap between two frames, and the polarity switch is checked right after a frame that changes `sck`'s resting level.

// File: rtl/spi_cmdq_pkg.sv
package spi_cmdq_pkg;
  localparam int DATAW = 16;
  localparam int IDXW  = 4;
  localparam int DIVW  = 8;

  typedef struct packed {
    logic [IDXW-1:0] sizeM1;
    logic            cpol;
    logic            cpha;
    logic            lsbFirst;
    logic [DIVW-1:0] halfDiv;
  } spiAttr_t;

  // strobes from the frame engine to the datapath
  typedef struct packed {
    logic            loadFrame;
    logic            sample;
    logic            commit;
    logic            active;
    logic [IDXW-1:0] txIdx;
    logic [IDXW-1:0] rxIdx;
  } spiStrobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD} engState_t;

  localparam spiAttr_t ATTR_RESET = '{sizeM1: IDXW'(7), cpol: 1'b0, cpha: 1'b0,
                                      lsbFirst: 1'b0, halfDiv: DIVW'(1)};
endpackage

// File: rtl/spi_cmdq_datapath.sv
module spi_cmdq_datapath
  import spi_cmdq_pkg::*;
#(
  parameter int NCS = 6,
  parameter int NATTR = 2,
  parameter int QDEPTH = 4,
  localparam int CNTW = $clog2(QDEPTH + 1),
  localparam int PTRW = $clog2(QDEPTH),
  localparam int ATTRW = $clog2(NATTR),
  localparam int CFGAW = $clog2(NATTR + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFGAW-1:0]  cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic              pushEn,
  input  logic [31:0]       pushWord,
  input  logic              popEn,
  input  logic              miso,
  input  spiStrobes_t       strobes,
  output logic [DATAW-1:0]  popData,
  output logic [CNTW-1:0]   txCount,
  output logic [CNTW-1:0]   rxCount,
  output logic              txOverflow,
  output logic              txReady,
  output logic              txFlush,
  output logic              enable,
  output logic              halt,
  output logic [NCS-1:0]    idleHigh,
  output spiAttr_t          frameAttr,
  output logic [NCS-1:0]    frameCs,
  output logic              frameCont,
  output logic              mosi
);
  localparam int CS_LSB = 16;
  localparam int ATTR_LSB = 24;
  localparam int CONT_BIT = 31;

  logic flushTxQ, flushRxQ;
  spiAttr_t attrQ [NATTR];

  logic [31:0] txMem [QDEPTH];
  logic [PTRW-1:0] txRd, txWr, rxRd, rxWr;
  logic [CNTW-1:0] txCnt, rxCnt;
  logic [DATAW-1:0] rxMem [QDEPTH];
  logic [DATAW-1:0] frameData, rxWord;
  logic [31:0] txHead;
  logic txPush, rxPush, rxPop;
  logic [IDXW-1:0] txPos, rxPos;
  logic unusedOk;

  function automatic logic [PTRW-1:0] nextPtr(input logic [PTRW-1:0] p);
    return (p == PTRW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      halt <= 1'b0;
      flushTxQ <= 1'b0;
      flushRxQ <= 1'b0;
      idleHigh <= '1;
    end else begin
      flushTxQ <= 1'b0;
      flushRxQ <= 1'b0;
      if (cfgWe && cfgAddr == '0) begin
        enable <= cfgWdata[0];
        halt <= cfgWdata[1];
        flushTxQ <= cfgWdata[2];
        flushRxQ <= cfgWdata[3];
        idleHigh <= cfgWdata[8 +: NCS];
      end
    end
  end

  for (genvar k = 0; k < NATTR; k++) begin : g_attr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) attrQ[k] <= ATTR_RESET;
      else if (cfgWe && cfgAddr == CFGAW'(k + 1))
        attrQ[k] <= '{sizeM1: cfgWdata[0 +: IDXW], cpol: cfgWdata[4], cpha: cfgWdata[5],
                      lsbFirst: cfgWdata[6], halfDiv: cfgWdata[8 +: DIVW]};
    end
  end

  // transmit queue
  assign txPush = pushEn && (txCnt < CNTW'(QDEPTH));
  assign txHead = txMem[txRd];

  always_ff @(posedge clk) begin
    if (txPush && !flushTxQ) txMem[txWr] <= pushWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txRd <= '0;
      txWr <= '0;
      txCnt <= '0;
      txOverflow <= 1'b0;
    end else if (flushTxQ) begin
      txCnt <= '0;
      txRd <= txWr;
      txOverflow <= 1'b0;
    end else begin
      if (txPush) txWr <= nextPtr(txWr);
      if (strobes.loadFrame) txRd <= nextPtr(txRd);
      txCnt <= txCnt + CNTW'(txPush) - CNTW'(strobes.loadFrame);
      if (pushEn && !txPush) txOverflow <= 1'b1;
    end
  end

  // frame latch and receive assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameAttr <= ATTR_RESET;
      frameData <= '0;
      frameCs <= '0;
      frameCont <= 1'b0;
      rxWord <= '0;
    end else if (strobes.loadFrame) begin
      frameAttr <= attrQ[txHead[ATTR_LSB +: ATTRW]];
      frameData <= txHead[DATAW-1:0];
      frameCs <= txHead[CS_LSB +: NCS];
      frameCont <= txHead[CONT_BIT];
      rxWord <= '0;
    end else if (strobes.sample) begin
      rxWord[rxPos] <= miso;
    end
  end

  assign txPos = frameAttr.lsbFirst ? strobes.txIdx : frameAttr.sizeM1 - strobes.txIdx;
  assign rxPos = frameAttr.lsbFirst ? strobes.rxIdx : frameAttr.sizeM1 - strobes.rxIdx;
  assign mosi = strobes.active & frameData[txPos];

  // receive queue
  assign rxPush = strobes.commit && (rxCnt < CNTW'(QDEPTH));
  assign rxPop = popEn && (rxCnt != '0);

  always_ff @(posedge clk) begin
    if (rxPush && !flushRxQ) rxMem[rxWr] <= rxWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxRd <= '0;
      rxWr <= '0;
      rxCnt <= '0;
    end else if (flushRxQ) begin
      rxCnt <= '0;
      rxRd <= rxWr;
    end else begin
      if (rxPush) rxWr <= nextPtr(rxWr);
      if (rxPop) rxRd <= nextPtr(rxRd);
      rxCnt <= rxCnt + CNTW'(rxPush) - CNTW'(rxPop);
    end
  end

  assign popData = rxMem[rxRd];
  assign txCount = txCnt;
  assign rxCount = rxCnt;
  assign txFlush = flushTxQ;
  assign txReady = (txCnt != '0) && !flushTxQ;
  assign unusedOk = ^{cfgWdata, txHead};
endmodule

// File: rtl/spi_cmdq_ctrl.sv
module spi_cmdq_ctrl
  import spi_cmdq_pkg::*;
#(
  parameter int NCS = 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic           halt,
  input  logic           txReady,
  input  spiAttr_t       frameAttr,
  input  logic [NCS-1:0] frameCs,
  input  logic           frameCont,
  output spiStrobes_t    strobes,
  output logic           running,
  output logic           sck,
  output logic [NCS-1:0] activeCs
);
  localparam int EDGEW = IDXW + 2;

  engState_t state;
  logic [DIVW-1:0] divCnt;
  logic [EDGEW-1:0] edgeCnt, lastEdge, txRaw, sizeWide;
  logic tog, halfDone;
  logic [NCS-1:0] heldCs;

  assign halfDone = divCnt == frameAttr.halfDiv;
  assign lastEdge = EDGEW'({frameAttr.sizeM1, 1'b1});
  assign sizeWide = EDGEW'(frameAttr.sizeM1);

  always_comb begin
    if (frameAttr.cpha) txRaw = (edgeCnt == '0) ? '0 : (edgeCnt - 1'b1) >> 1;
    else                txRaw = edgeCnt >> 1;
    strobes.loadFrame = (state == ST_IDLE) && enable && !halt && txReady;
    strobes.sample = (state == ST_SHIFT) && halfDone && (edgeCnt[0] == frameAttr.cpha);
    strobes.commit = (state == ST_HOLD) && halfDone;
    strobes.active = state != ST_IDLE;
    strobes.txIdx = (txRaw > sizeWide) ? frameAttr.sizeM1 : txRaw[IDXW-1:0];
    strobes.rxIdx = edgeCnt[IDXW:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      divCnt <= '0;
      edgeCnt <= '0;
      tog <= 1'b0;
      heldCs <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (strobes.loadFrame) begin
          state <= ST_SETUP;
          divCnt <= '0;
          edgeCnt <= '0;
          tog <= 1'b0;
        end
        ST_SETUP: if (halfDone) begin
          state <= ST_SHIFT;
          divCnt <= '0;
        end else divCnt <= divCnt + 1'b1;
        ST_SHIFT: if (halfDone) begin
          divCnt <= '0;
          tog <= ~tog;
          edgeCnt <= edgeCnt + 1'b1;
          if (edgeCnt == lastEdge) state <= ST_HOLD;
        end else divCnt <= divCnt + 1'b1;
        ST_HOLD: if (halfDone) begin
          state <= ST_IDLE;
          divCnt <= '0;
          heldCs <= frameCont ? frameCs : '0;
        end else divCnt <= divCnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign running = state != ST_IDLE;
  assign sck = frameAttr.cpol ^ tog;
  assign activeCs = running ? frameCs : heldCs;
endmodule

// File: rtl/spi_cmdq_master.sv
module spi_cmdq_master
  import spi_cmdq_pkg::*;
#(
  parameter int NCS = 6,
  parameter int NATTR = 2,
  parameter int QDEPTH = 4,
  localparam int CNTW = $clog2(QDEPTH + 1),
  localparam int CFGAW = $clog2(NATTR + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFGAW-1:0] cfgAddr,
  input  logic [31:0]      cfgWdata,
  input  logic             pushEn,
  input  logic [31:0]      pushWord,
  input  logic             popEn,
  output logic [15:0]      popData,
  output logic [CNTW-1:0]  txCount,
  output logic [CNTW-1:0]  rxCount,
  output logic             txOverflow,
  output logic             running,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NCS-1:0]   csOut
);
  spiStrobes_t strobes;
  spiAttr_t frameAttr;
  logic [NCS-1:0] frameCs, idleHigh, activeCs;
  logic frameCont, txReady, txFlush, enable, halt;

  spi_cmdq_datapath #(.NCS(NCS), .NATTR(NATTR), .QDEPTH(QDEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .pushEn(pushEn), .pushWord(pushWord), .popEn(popEn), .miso(miso),
    .strobes(strobes), .popData(popData), .txCount(txCount), .rxCount(rxCount),
    .txOverflow(txOverflow), .txReady(txReady), .txFlush(txFlush), .enable(enable),
    .halt(halt), .idleHigh(idleHigh), .frameAttr(frameAttr), .frameCs(frameCs),
    .frameCont(frameCont), .mosi(mosi)
  );

  spi_cmdq_ctrl #(.NCS(NCS)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .halt(halt), .txReady(txReady),
    .frameAttr(frameAttr), .frameCs(frameCs), .frameCont(frameCont),
    .strobes(strobes), .running(running), .sck(sck), .activeCs(activeCs)
  );

  assign csOut = idleHigh ^ activeCs;
endmodule

// File: rtl/spi_cmdq_checker.sv
module spi_cmdq_checker #(
  parameter int NCS = 6,
  parameter int QDEPTH = 4,
  localparam int CNTW = $clog2(QDEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            pushEn,
  input logic [CNTW-1:0] txCount,
  input logic [CNTW-1:0] rxCount,
  input logic            txOverflow,
  input logic            running,
  input logic            sck,
  input logic [NCS-1:0]  csOut,
  input logic            txFlush,
  input logic            halt,
  input logic            frameCont,
  input logic [NCS-1:0]  idleHigh
);
  p_txcount_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CNTW'(QDEPTH));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    pushEn && txCount == CNTW'(QDEPTH) && !txFlush |=> txOverflow);

  p_sck_rest_r5: assert property (@(posedge clk) disable iff (!rstN)
    !running && $past(!running) |-> $stable(sck));

  p_rx_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> rxCount <= $past(rxCount) + 1'b1);

  p_cs_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) && !frameCont |-> csOut == idleHigh);

  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !running && halt |=> !running);

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    txFlush |=> txCount == '0);
endmodule

bind spi_cmdq_master spi_cmdq_checker #(.NCS(NCS), .QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .pushEn(pushEn), .txCount(txCount), .rxCount(rxCount),
  .txOverflow(txOverflow), .running(running), .sck(sck), .csOut(csOut),
  .txFlush(txFlush), .halt(halt), .frameCont(frameCont), .idleHigh(idleHigh)
);

// File: tb/spi_cmdq_master_tb.sv
module spi_cmdq_master_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 1'b0, pushEn = 1'b0, popEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0, pushWord = '0;
  logic [15:0] popData;
  logic [2:0] txCount, rxCount;
  logic txOverflow, running, sck, mosi, miso;
  logic [5:0] csOut;

  int nChecks = 0, nFail = 0, cyc = 0;

  // monitor state
  logic prevSck = 1'b0, wasRun = 1'b0, monCpol = 1'b0, monCpha = 1'b0;
  int runCycles = 0, edges = 0;
  logic [5:0] csDuring = '0;
  bit seen[$];
  logic [15:0] rxModel[$];

  always #2.5 clk = ~clk;
  assign miso = ~mosi;

  spi_cmdq_master dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .pushEn(pushEn), .pushWord(pushWord), .popEn(popEn), .popData(popData),
    .txCount(txCount), .rxCount(rxCount), .txOverflow(txOverflow), .running(running),
    .sck(sck), .mosi(mosi), .miso(miso), .csOut(csOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL R12 watchdog act=%0d exp=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (sck != prevSck && !(running && !wasRun)) begin
      edges++;
      if ((prevSck == monCpol) != monCpha) seen.push_back(mosi);
    end
    if (running) runCycles++;
    if (running && !wasRun) csDuring = csOut;
    prevSck = sck;
    wasRun = running;
  end

  function automatic logic [31:0] mkWord(input logic [15:0] d, input int csBit,
                                         input int attr, input bit cont);
    logic [31:0] w;
    w = '0;
    w[15:0] = d;
    w[16 + csBit] = 1'b1;
    w[24] = attr[0];
    w[31] = cont;
    return w;
  endfunction

  task automatic wrCfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic wrCtrl(input bit en, input bit hlt, input bit ftx, input bit frx,
                        input logic [5:0] idle);
    wrCfg(2'd0, {16'd0, 2'b00, idle, 4'd0, frx, ftx, hlt, en});
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    pushEn = 1'b1; pushWord = w;
    @(negedge clk);
    pushEn = 1'b0;
  endtask

  task automatic popCheck(input string tag, input logic [15:0] exp);
    @(negedge clk);
    chk(tag, popData, exp);
    popEn = 1'b1;
    @(negedge clk);
    popEn = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (running || txCount != 0) @(negedge clk);
  endtask

  function automatic logic [15:0] maskN(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic runFrame(input string tag, input logic [15:0] d, input int csBit,
                          input int attr, input bit cont, input int n, input bit lsb,
                          input int div, input bit cp, input bit ph);
    logic [15:0] serAct, serExp;
    monCpol = cp; monCpha = ph;
    seen.delete();
    edges = 0; runCycles = 0;
    push(mkWord(d, csBit, attr, cont));
    waitIdle();
    serAct = '0; serExp = '0;
    foreach (seen[k]) serAct = {serAct[14:0], seen[k]};
    for (int k = 0; k < n; k++) serExp = {serExp[14:0], d[lsb ? k : n - 1 - k]};
    chk({tag, " R6 R3 serial order"}, serAct, serExp);
    chk({tag, " R4 sck edges"}, edges, 2 * n);
    chk({tag, " R4 running cycles"}, runCycles, (div + 1) * (2 * n + 2));
    chk({tag, " R7 rx count"}, rxCount, 1);
    popCheck({tag, " R7 rx word"}, ~d & maskN(n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 txCount reset", txCount, 0);
    chk("R12 rxCount reset", rxCount, 0);
    chk("R12 running reset", running, 0);
    chk("R12 sck reset", sck, 0);
    chk("R12 cs reset", csOut, 6'h3F);
    chk("R12 overflow reset", txOverflow, 0);

    wrCtrl(1, 0, 0, 0, 6'h3F);
    wrCfg(2'd1, 32'h0000_0107);           // set 0: 8 bits, mode 0, msb first, div 1
    wrCfg(2'd2, 32'h0000_007F);           // set 1: 16 bits, cpol 1, cpha 1, lsb first, div 0

    runFrame("f1", 16'h00A5, 0, 0, 0, 8, 0, 1, 0, 0);
    chk("R9 cs during f1", csDuring, 6'h3E);
    chk("R8 cs after f1", csOut, 6'h3F);

    runFrame("f2", 16'h1234, 2, 1, 0, 16, 1, 0, 1, 1);
    chk("R9 cs during f2", csDuring, 6'h3B);
    chk("R5 sck rests at polarity 1", sck, 1);

    // held chip select across two frames
    runFrame("f3", 16'h003C, 1, 0, 1, 8, 0, 1, 0, 0);
    chk("R8 cs held after continuous frame", csOut, 6'h3D);
    chk("R5 sck rests at polarity 0", sck, 0);
    runFrame("f4", 16'h00C3, 1, 0, 0, 8, 0, 1, 0, 0);
    chk("R8 cs released after last frame", csOut, 6'h3F);

    // per-line idle level
    wrCtrl(1, 0, 0, 0, 6'h37);
    chk("R9 idle-low line at rest", csOut, 6'h37);
    runFrame("f5", 16'h0000, 3, 0, 0, 8, 0, 1, 0, 0);
    chk("R9 idle-low line driven high", csDuring, 6'h3F);
    chk("R9 idle-low line back low", csOut, 6'h37);

    // halt, fill, overflow, flush
    wrCtrl(1, 1, 0, 0, 6'h3F);
    for (int k = 0; k < 5; k++) push(mkWord(16'(8'h10 + k), 0, 0, 0));
    repeat (4) @(negedge clk);
    chk("R1 tx queue full at 4", txCount, 4);
    chk("R2 overflow set", txOverflow, 1);
    chk("R10 halt blocks frames", running, 0);
    wrCtrl(1, 1, 1, 0, 6'h3F);
    @(negedge clk);
    chk("R11 tx flush empties", txCount, 0);
    chk("R2 overflow cleared by flush", txOverflow, 0);
    for (int k = 0; k < 4; k++) push(mkWord(16'(8'h21 * (k + 1)), 0, 0, 0));
    chk("R11 flush bit self-cleared", txCount, 4);
    for (int k = 0; k < 4; k++) rxModel.push_back(~16'(8'h21 * (k + 1)) & 16'h00FF);
    wrCtrl(1, 0, 0, 0, 6'h3F);
    waitIdle();
    chk("R7 rx count after four frames", rxCount, 4);
    push(mkWord(16'h0077, 0, 0, 0));
    waitIdle();
    chk("R7 rx full drops newest", rxCount, 4);
    chk("R1 tx drained", txCount, 0);
    popCheck("R7 rx order 0", rxModel.pop_front());
    popCheck("R7 rx order 1", rxModel.pop_front());
    chk("R7 rx count after two pops", rxCount, 2);
    wrCtrl(1, 0, 0, 1, 6'h3F);
    @(negedge clk);
    chk("R11 rx flush empties", rxCount, 0);

    // master enable clear
    wrCtrl(0, 0, 0, 0, 6'h3F);
    push(mkWord(16'h0055, 0, 0, 0));
    repeat (60) @(negedge clk);
    chk("R10 disabled keeps word", txCount, 1);
    chk("R10 disabled no frame", rxCount, 0);
    wrCtrl(1, 0, 0, 0, 6'h3F);
    waitIdle();
    chk("R10 enable resumes", rxCount, 1);
    popCheck("R10 resumed rx word", 16'h00AA);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule